// File: doc/BRIEF.md
# 16-bit Trigger-Reset Timer

This block is a 16-bit up-counter. It advances on one of two sources: a one-cycle enable at the instruction rate, or the rising edges of an external clock pin. The selected source first passes through a divide-by-1/2/4/8 prescaler. When the count rolls over from 0xFFFF to 0x0000 it sets a sticky overflow flag. That flag raises the interrupt output when the interrupt enable is also set.

A compare unit elsewhere in the chip can pulse the event input to clear the count to zero. The flag is not touched when this happens. Used this way, the compare register sets the timer's period.

Software reaches the block through four byte-wide registers. They hold the control bits, the low and high count bytes, and the flag and enable bits. A 16-bit mode makes reads and writes of the count coherent across its two bytes.

Top module: `trigTimer16`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the count reads 0x0000, the flag/enable register (address 3) reads 0x00 and irqOut is low.
- R2: While the run bit (control bit 0) is set, the count steps by one for every 1, 2, 4 or 8 source pulses, selected by control bits 5:4 = 00, 01, 10, 11.
- R3: A step from 0xFFFF wraps the count to 0x0000 and sets the overflow flag (address 3 bit 0). The flag stays set through later counting until software writes 0 to that bit.
- R4: irqOut is high exactly when the overflow flag and the interrupt enable (address 3 bit 1) are both set.
- R5: An event pulse clears the count to 0x0000 without setting the flag. This applies in internal mode and in synchronized external mode, even in the same cycle as a step from 0xFFFF.
- R6: When a count write and an event pulse fall in the same cycle, the written value is loaded and the clear is dropped.
- R7: With external source (control bit 1 = 1) and sync disabled (control bit 2 = 1), an event pulse leaves the count unchanged.
- R8: In external mode, each rising edge of extClk counts as one source pulse, after a two-flop synchronizer. tickEn has no effect in this mode.
- R9: With the run bit clear, tickEn does not change the count.
- R10: With control bit 7 set, reading the low byte (address 1) captures the high byte, and a later read of address 2 returns the captured value. Writing address 2 only fills a buffer, and the following low-byte write loads both bytes at once.
- R11: With control bit 7 clear, writes to address 1 or 2 load that count byte at once, and address 2 reads the live high byte.
- R12: Any write to the count or to the control register restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Instruction-rate count enable (internal source) |
| extClk | input | 1 | External clock pin (external source) |
| cmpEvent | input | 1 | Compare-match event pulse that clears the count |
| busAddr | input | 2 | Register address: 0 control, 1 count low, 2 count high, 3 flag/enable |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 8 | Register write data |
| busRdEn | input | 1 | Register read strobe (causes the high-byte capture) |
| busRdData | output | 8 | Register read data for busAddr, combinational |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are coincidences at one clock edge. One is an event pulse landing in the same cycle as a count write. Another is an event pulse landing in the cycle where a step from 0xFFFF would set the flag. The bench drives the write strobe, or tickEn, together with cmpEvent on the same falling edge, so both are seen at one rising edge. It then reads back the count and the flag. The coherent-read case is reached in a similar way: the counter is preloaded just below a high-byte carry, left running, and the high byte is read several cycles after the low byte.

// File: rtl/trigTimerPkg.sv
`timescale 1ns/1ps
package trigTimerPkg;
  localparam int BYTE_W    = 8;
  localparam int CNT_W     = 2 * BYTE_W;
  localparam int PRE_SEL_W = 2;

  // control register bit positions
  localparam int CTL_RUN  = 0;
  localparam int CTL_EXT  = 1;
  localparam int CTL_NSYN = 2;
  localparam int CTL_PRE  = 4;
  localparam int CTL_RW16 = 7;
  localparam logic [BYTE_W-1:0] CTL_MASK = 8'hB7;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_LO   = 2'd1,
    ADDR_HI   = 2'd2,
    ADDR_IRQ  = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic                 run;
    logic                 extSel;
    logic                 syncDis;
    logic [PRE_SEL_W-1:0] preSel;
  } tmrCfg_t;

  typedef struct packed {
    logic              wrLo;
    logic              wrHi;
    logic              wrFull;
    logic              preClr;
    logic [BYTE_W-1:0] wrData;
    logic [BYTE_W-1:0] hiBuf;
  } cntStrobe_t;
endpackage

// File: rtl/trigTimerPrescaler.sv
`timescale 1ns/1ps
module trigTimerPrescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcPulse,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             advance
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  generate
    if (DIV_W == 0) begin : gNoDiv
      assign advance = srcPulse;
    end else begin : gDiv
      logic [DIV_W-1:0] preCnt;
      logic [DIV_W-1:0] divMask;
      logic             atTerm;

      assign divMask = ~({DIV_W{1'b1}} << sel);
      assign atTerm  = (preCnt == divMask);
      assign advance = srcPulse && atTerm;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         preCnt <= '0;
        else if (clr)      preCnt <= '0;
        else if (srcPulse) preCnt <= atTerm ? '0 : preCnt + 1'b1;
      end

      // R12: a restart means no step on the next edge unless dividing by one
      assert_pre_restart_R12: assert property (@(posedge clk) disable iff (!rstN)
        clr |=> (sel == '0 || !advance));
    end
  endgenerate
endmodule

// File: rtl/trigTimerDatapath.sv
`timescale 1ns/1ps
module trigTimerDatapath
  import trigTimerPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             extClk,
  input  logic             cmpEvent,
  input  tmrCfg_t          cfg,
  input  cntStrobe_t       strobe,
  output logic [CNT_W-1:0] cntVal,
  output logic             ovfPulse
);
  logic [SYNC_STAGES:0] syncChain;
  logic extRise, srcPulse, advance, anyWr, trigOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-1:0], extClk};
  end
  assign extRise  = syncChain[SYNC_STAGES-1] && !syncChain[SYNC_STAGES];
  assign srcPulse = cfg.run && (cfg.extSel ? extRise : tickEn);

  trigTimerPrescaler #(.SEL_W(PRE_SEL_W)) preI (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse),
    .clr(strobe.preClr), .sel(cfg.preSel), .advance(advance));

  assign anyWr  = strobe.wrLo || strobe.wrHi || strobe.wrFull;
  assign trigOk = cmpEvent && !(cfg.extSel && cfg.syncDis);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntVal <= '0;
    else if (anyWr) begin
      if (strobe.wrFull)    cntVal <= {strobe.hiBuf, strobe.wrData};
      else if (strobe.wrLo) cntVal[BYTE_W-1:0] <= strobe.wrData;
      else                  cntVal[CNT_W-1:BYTE_W] <= strobe.wrData;
    end
    else if (trigOk)  cntVal <= '0;
    else if (advance) cntVal <= cntVal + 1'b1;
  end

  assign ovfPulse = advance && !anyWr && !trigOk && (cntVal == {CNT_W{1'b1}});

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !anyWr && !trigOk) |=> cntVal == $past(cntVal) + 1'b1);
  assert_trig_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (trigOk && !anyWr) |=> cntVal == '0);
  assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmpEvent && strobe.wrFull) |=> cntVal == $past({strobe.hiBuf, strobe.wrData}));
  assert_unsync_ignore_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.extSel && cfg.syncDis && !anyWr && !advance) |=> $stable(cntVal));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.run && !anyWr && !trigOk) |=> $stable(cntVal));
endmodule

// File: rtl/trigTimerCtrl.sv
`timescale 1ns/1ps
module trigTimerCtrl
  import trigTimerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [BYTE_W-1:0] busRdData,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              ovfPulse,
  output tmrCfg_t           cfg,
  output cntStrobe_t        strobe,
  output logic              irqOut
);
  regAddr_e          addrE;
  logic [BYTE_W-1:0] ctrlReg, hiWrBuf, hiRdBuf;
  logic              ovfFlag, irqEn, rw16, ctrlWr, irqWr;

  assign addrE  = regAddr_e'(busAddr);
  assign rw16   = ctrlReg[CTL_RW16];
  assign ctrlWr = busWrEn && addrE == ADDR_CTRL;
  assign irqWr  = busWrEn && addrE == ADDR_IRQ;

  assign cfg.run     = ctrlReg[CTL_RUN];
  assign cfg.extSel  = ctrlReg[CTL_EXT];
  assign cfg.syncDis = ctrlReg[CTL_NSYN];
  assign cfg.preSel  = ctrlReg[CTL_PRE +: PRE_SEL_W];

  assign strobe.wrLo   = busWrEn && addrE == ADDR_LO && !rw16;
  assign strobe.wrFull = busWrEn && addrE == ADDR_LO && rw16;
  assign strobe.wrHi   = busWrEn && addrE == ADDR_HI && !rw16;
  assign strobe.preClr = ctrlWr || strobe.wrLo || strobe.wrFull || strobe.wrHi;
  assign strobe.wrData = busWrData;
  assign strobe.hiBuf  = hiWrBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      hiWrBuf <= '0;
      hiRdBuf <= '0;
      ovfFlag <= 1'b0;
      irqEn   <= 1'b0;
    end else begin
      if (ctrlWr) ctrlReg <= busWrData & CTL_MASK;
      if (busWrEn && addrE == ADDR_HI && rw16) hiWrBuf <= busWrData;
      if (busRdEn && addrE == ADDR_LO && rw16) hiRdBuf <= cntVal[CNT_W-1:BYTE_W];
      if (ovfPulse)   ovfFlag <= 1'b1;
      else if (irqWr) ovfFlag <= busWrData[0];
      if (irqWr) irqEn <= busWrData[1];
    end
  end

  always_comb begin
    unique case (addrE)
      ADDR_CTRL: busRdData = ctrlReg;
      ADDR_LO:   busRdData = cntVal[BYTE_W-1:0];
      ADDR_HI:   busRdData = rw16 ? hiRdBuf : cntVal[CNT_W-1:BYTE_W];
      default:   busRdData = {{(BYTE_W-2){1'b0}}, irqEn, ovfFlag};
    endcase
  end

  assign irqOut = ovfFlag && irqEn;

  // R3: hardware only raises the flag on a wrap out of 0xFFFF
  assert_flag_from_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ovfFlag) && !$past(irqWr)) |-> $past(cntVal) == {CNT_W{1'b1}});
  // R4: with the enable off and untouched, no interrupt appears
  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEn && !irqWr) |=> !irqOut);
  // R10: a high-byte write in 16-bit mode never touches the counter directly
  assert_hi_buffered_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && addrE == ADDR_HI && rw16) |-> !(strobe.wrHi || strobe.wrLo || strobe.wrFull));
endmodule

// File: rtl/trigTimer16.sv
`timescale 1ns/1ps
module trigTimer16
  import trigTimerPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              extClk,
  input  logic              cmpEvent,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [BYTE_W-1:0] busRdData,
  output logic              irqOut
);
  tmrCfg_t          cfg;
  cntStrobe_t       strobe;
  logic [CNT_W-1:0] cntVal;
  logic             ovfPulse;

  trigTimerCtrl ctrlI (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .cntVal(cntVal), .ovfPulse(ovfPulse), .cfg(cfg), .strobe(strobe),
    .irqOut(irqOut));

  trigTimerDatapath #(.SYNC_STAGES(SYNC_STAGES)) dpI (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .extClk(extClk),
    .cmpEvent(cmpEvent), .cfg(cfg), .strobe(strobe),
    .cntVal(cntVal), .ovfPulse(ovfPulse));
endmodule

// File: tb/trigTimer16_tb.sv
`timescale 1ns/1ps
module trigTimer16_tb_top;
  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, extClk = 1'b0, cmpEvent = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic irqOut;
  int compared = 0, mismatched = 0;

  always #2 clk = ~clk;

  trigTimer16 dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .extClk(extClk), .cmpEvent(cmpEvent),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData), .busRdEn(busRdEn),
    .busRdData(busRdData), .irqOut(irqOut));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic readCount(output logic [15:0] v);
    logic [7:0] lo, hi;
    busRead(2'd1, lo);
    busRead(2'd2, hi);
    v = {hi, lo};
  endtask

  task automatic setCount8(input logic [15:0] v);
    busWrite(2'd1, v[7:0]);
    busWrite(2'd2, v[15:8]);
  endtask

  task automatic ticks(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic pulseEvent();
    cmpEvent = 1'b1;
    @(negedge clk);
    cmpEvent = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] d; logic [15:0] c;
    busRead(2'd0, d); check("R1 ctrl", d, 8'h00);
    readCount(c);     check("R1 count", c, 16'h0000);
    busRead(2'd3, d); check("R1 flag/enable", d, 8'h00);
    check("R1 irqOut", irqOut, 1'b0);
  endtask

  task automatic testHold();
    logic [15:0] c;
    ticks(10);
    readCount(c); check("R9 stopped count", c, 16'h0000);
  endtask

  task automatic testPrescale();
    logic [15:0] c;
    for (int ps = 0; ps < 4; ps++) begin
      busWrite(2'd0, 8'h00);
      setCount8(16'h0000);
      busWrite(2'd0, 8'(8'h01 | (ps << 4)));
      ticks(16);
      busWrite(2'd0, 8'(ps << 4));
      readCount(c); check("R2 prescale", c, 16'(16 >> ps));
    end
  endtask

  task automatic testPreClear();
    logic [7:0] d;
    busWrite(2'd0, 8'h00);
    setCount8(16'h0000);
    busWrite(2'd0, 8'h21);
    ticks(3);
    busWrite(2'd1, 8'h00);
    ticks(3);
    busRead(2'd1, d); check("R12 restart after count write", d, 8'h00);
    ticks(1);
    busRead(2'd1, d); check("R12 step after full divide", d, 8'h01);
    busWrite(2'd0, 8'h00);
  endtask

  task automatic testWrapFlag();
    logic [7:0] d; logic [15:0] c;
    busWrite(2'd0, 8'h00);
    setCount8(16'hFFFE);
    busWrite(2'd3, 8'h02);
    busWrite(2'd0, 8'h01);
    ticks(1);
    readCount(c);     check("R3 before wrap", c, 16'hFFFF);
    busRead(2'd3, d); check("R3 flag clear before wrap", d, 8'h02);
    ticks(1);
    readCount(c);     check("R3 wrap to zero", c, 16'h0000);
    busRead(2'd3, d); check("R3 flag set on wrap", d, 8'h03);
    check("R4 irq on wrap", irqOut, 1'b1);
    ticks(3);
    busRead(2'd3, d); check("R3 flag sticky", d, 8'h03);
    busWrite(2'd0, 8'h00);
    busWrite(2'd3, 8'h02);
    busRead(2'd3, d); check("R3 flag cleared by software", d, 8'h02);
    check("R4 irq low after clear", irqOut, 1'b0);
    busWrite(2'd3, 8'h01);
    check("R4 flag without enable", irqOut, 1'b0);
    busWrite(2'd3, 8'h03);
    check("R4 flag with enable", irqOut, 1'b1);
    busWrite(2'd3, 8'h00);
  endtask

  task automatic testTrigger();
    logic [7:0] d; logic [15:0] c;
    busWrite(2'd0, 8'h00);
    setCount8(16'h1234);
    pulseEvent();
    readCount(c);     check("R5 event clears", c, 16'h0000);
    busRead(2'd3, d); check("R5 no flag from event", d, 8'h00);
    setCount8(16'hFFFF);
    busWrite(2'd0, 8'h01);
    tickEn = 1'b1; cmpEvent = 1'b1;
    @(negedge clk);
    tickEn = 1'b0; cmpEvent = 1'b0;
    busWrite(2'd0, 8'h00);
    readCount(c);     check("R5 event beats wrap", c, 16'h0000);
    busRead(2'd3, d); check("R5 no flag when event meets wrap", d, 8'h00);
  endtask

  task automatic testUnsync();
    logic [15:0] c;
    busWrite(2'd0, 8'h06);
    setCount8(16'h0042);
    pulseEvent();
    readCount(c); check("R7 unsync ignores event", c, 16'h0042);
    busWrite(2'd0, 8'h02);
    pulseEvent();
    readCount(c); check("R5 synced external clears", c, 16'h0000);
    busWrite(2'd0, 8'h00);
  endtask

  task automatic testWritePriority();
    logic [7:0] lo, hi;
    busWrite(2'd0, 8'h00);
    setCount8(16'h0500);
    busAddr = 2'd1; busWrData = 8'h77; busWrEn = 1'b1; cmpEvent = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; cmpEvent = 1'b0;
    busRead(2'd1, lo); busRead(2'd2, hi);
    check("R6 byte write beats event", {hi, lo}, 16'h0577);
    busWrite(2'd0, 8'h80);
    busWrite(2'd2, 8'hAB);
    busRead(2'd1, lo); busRead(2'd2, hi);
    check("R10 high write only buffered", {hi, lo}, 16'h0577);
    busAddr = 2'd1; busWrData = 8'hCD; busWrEn = 1'b1; cmpEvent = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; cmpEvent = 1'b0;
    busRead(2'd1, lo); busRead(2'd2, hi);
    check("R6 16-bit load beats event", {hi, lo}, 16'hABCD);
  endtask

  task automatic testCoherentRead();
    logic [7:0] lo, hi;
    busWrite(2'd0, 8'h80);
    busWrite(2'd2, 8'h12);
    busWrite(2'd1, 8'hFD);
    busWrite(2'd0, 8'h81);
    tickEn = 1'b1;
    busRead(2'd1, lo); check("R10 low byte at capture", lo, 8'hFD);
    repeat (5) @(negedge clk);
    busRead(2'd2, hi); check("R10 captured high byte", hi, 8'h12);
    tickEn = 1'b0;
    busWrite(2'd0, 8'h80);
    busRead(2'd1, lo); busRead(2'd2, hi);
    check("R10 live count after run", {hi, lo}, 16'h1304);
    busWrite(2'd0, 8'h00);
    busRead(2'd2, hi); check("R11 8-bit high reads live", hi, 8'h13);
  endtask

  task automatic extPulses(input int n);
    for (int i = 0; i < n; i++) begin
      extClk = 1'b1; repeat (3) @(negedge clk);
      extClk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic testExternal();
    logic [15:0] c;
    busWrite(2'd0, 8'h00);
    setCount8(16'h0000);
    readCount(c); check("R11 8-bit byte writes", c, 16'h0000);
    busWrite(2'd0, 8'h03);
    tickEn = 1'b1;
    extPulses(5);
    tickEn = 1'b0;
    busWrite(2'd0, 8'h02);
    readCount(c); check("R8 external edges div1", c, 16'h0005);
    setCount8(16'h0000);
    busWrite(2'd0, 8'h13);
    extPulses(6);
    busWrite(2'd0, 8'h12);
    readCount(c); check("R8 external edges div2", c, 16'h0003);
    busWrite(2'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHold();
    testPrescale();
    testPreClear();
    testWrapFlag();
    testTrigger();
    testUnsync();
    testWritePriority();
    testCoherentRead();
    testExternal();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule